// File: doc/BRIEF.md
# Smart Card Reset Sequencer

This block drives the reset contact of a smart card and powers the card down in an orderly way. Software issues a warm-reset strobe. The block pulls the card reset low, switches the interface into receive mode and holds the supply and the card clock steady. After a programmed number of card clock cycles it releases reset. It then waits a bounded number of card clock cycles for the first start bit of the answer-to-reset. If that start bit does not arrive in time, the block shuts the card down without software action.

Card removal, seen as a falling edge on the card-detect input, and a software shutdown request both send the block straight into its power-down state. Either one overrides whatever the block is doing. In the power-down state the reset contact and receive mode are dropped at once. The supply enable is withdrawn a fixed number of card clock ticks later, and the block then returns to idle. All counting advances only on the card clock enable tick.

Top module: `card_rst_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, card_rst_n, vcc_en, rx_mode and all three pulse outputs are 0.
- R2: A warm_rst_req in idle with card_present high, or in the watch or active state, gives card_rst_n=0, rx_mode=1 and vcc_en=1 on the next cycle. The supply is switched on from idle and left unchanged otherwise.
- R3: In the reset-low phase only card_clk_tick cycles are counted. card_rst_n goes to 1 on the clock edge of the rst_low_cycles-th tick, where a programmed 0 acts as 1. vcc_en does not change.
- R4: In the watch state, rx_start_bit in any cycle, however early, moves the block to active. rx_mode goes to 0, card_rst_n stays 1 and no timeout is raised.
- R5: In the watch state, the atr_limit-th tick with no start bit gives a one-cycle atr_tout_pulse together with deact_pulse, and card_rst_n=0. A start bit in that same cycle wins, and no timeout is raised.
- R6: A 1-to-0 change of card_present produces a one-cycle card_out_pulse in every state. Outside the power-down state it also enters power-down with deact_pulse, and this beats start bits, warm resets and timeouts in the same cycle.
- R7: sw_deact_req outside the power-down state enters power-down with deact_pulse and no card_out_pulse.
- R8: On entering power-down, card_rst_n=0 and rx_mode=0 at once. vcc_en drops on the VCC_OFF_TICKS-th tick (default 2). The block returns to idle on the DEACT_TICKS-th tick (default 4).
- R9: warm_rst_req during power-down has no effect. The supply still drops and idle is still reached on the same ticks, and reset stays low.
- R10: warm_rst_req in idle while card_present is low has no effect. All outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| warm_rst_req | input | 1 | Software warm-reset strobe |
| sw_deact_req | input | 1 | Software power-down request |
| card_present | input | 1 | Card detect, high when a card is seated |
| card_clk_tick | input | 1 | One-cycle enable per card clock cycle |
| rx_start_bit | input | 1 | Receiver saw a start bit |
| rst_low_cycles | input | CNT_W | Card clock cycles reset is held low |
| atr_limit | input | CNT_W | Card clock cycles allowed for the first start bit |
| card_rst_n | output | 1 | Card reset contact, active low |
| vcc_en | output | 1 | Card supply enable |
| rx_mode | output | 1 | Interface held in receive mode |
| deact_pulse | output | 1 | One-cycle pulse on entry to power-down |
| card_out_pulse | output | 1 | One-cycle pulse on card removal |
| atr_tout_pulse | output | 1 | One-cycle pulse when the start-bit window expires |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the start bit and the expiring tick of the watch window. The bench raises rx_start_bit in the same cycle as the atr_limit-th tick and expects the active state with no timeout pulse. The second pair is card removal and a start bit, with a warm-reset strobe raised in the same cycle as well. The bench expects card_out_pulse and deact_pulse with reset low, and it confirms the power-down timing on the ticks that follow.

// File: rtl/crs_pkg.sv
package crs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RST_LOW   = 3'd1,
        ST_ATR_WATCH = 3'd2,
        ST_ACTIVE    = 3'd3,
        ST_DEACT     = 3'd4
    } crs_state_e;
endpackage

// File: rtl/crs_fall_detect.sv
module crs_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic fell
);
    logic level_d, level_q;

    always_comb begin
        level_d = level_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_d;
    end

    assign fell = level_q & ~level_in;
endmodule

// File: rtl/crs_limit_hit.sv
module crs_limit_hit #(
    parameter int CNT_W = 16
) (
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    localparam int EXT_W = CNT_W + 1;
    logic [EXT_W-1:0] next_cnt;
    logic [EXT_W-1:0] eff_limit;

    always_comb begin
        next_cnt  = {1'b0, cnt} + EXT_W'(1);
        eff_limit = (limit == '0) ? EXT_W'(1) : {1'b0, limit};
        hit       = tick && (next_cnt >= eff_limit);
    end
endmodule

// File: rtl/card_rst_seq.sv
module card_rst_seq
    import crs_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int VCC_OFF_TICKS = 2,
    parameter int DEACT_TICKS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst_req,
    input  logic             sw_deact_req,
    input  logic             card_present,
    input  logic             card_clk_tick,
    input  logic             rx_start_bit,
    input  logic [CNT_W-1:0] rst_low_cycles,
    input  logic [CNT_W-1:0] atr_limit,
    output logic             card_rst_n,
    output logic             vcc_en,
    output logic             rx_mode,
    output logic             deact_pulse,
    output logic             card_out_pulse,
    output logic             atr_tout_pulse
);
    localparam logic [CNT_W-1:0] VCC_OFF_LIM = CNT_W'(VCC_OFF_TICKS);
    localparam logic [CNT_W-1:0] DONE_LIM    = CNT_W'(DEACT_TICKS);

    typedef struct packed {
        crs_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             vcc;
        logic             rst_n;
        logic             rx;
        logic             deact;
        logic             cout;
        logic             tout;
    } regs_t;

    regs_t r_d, r_q;
    logic  card_fall;
    logic  rst_hit, atr_hit, vcc_hit, done_hit;

    crs_fall_detect u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_in(card_present),
        .fell    (card_fall)
    );

    crs_limit_hit #(.CNT_W(CNT_W)) u_rst_lim (
        .tick(card_clk_tick), .cnt(r_q.cnt), .limit(rst_low_cycles), .hit(rst_hit)
    );
    crs_limit_hit #(.CNT_W(CNT_W)) u_atr_lim (
        .tick(card_clk_tick), .cnt(r_q.cnt), .limit(atr_limit), .hit(atr_hit)
    );
    crs_limit_hit #(.CNT_W(CNT_W)) u_vcc_lim (
        .tick(card_clk_tick), .cnt(r_q.cnt), .limit(VCC_OFF_LIM), .hit(vcc_hit)
    );
    crs_limit_hit #(.CNT_W(CNT_W)) u_done_lim (
        .tick(card_clk_tick), .cnt(r_q.cnt), .limit(DONE_LIM), .hit(done_hit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.deact = 1'b0;
        r_d.tout  = 1'b0;
        r_d.cout  = card_fall;
        if ((card_fall || sw_deact_req) && r_q.state != ST_DEACT) begin
            r_d.state = ST_DEACT;
            r_d.cnt   = '0;
            r_d.rst_n = 1'b0;
            r_d.rx    = 1'b0;
            r_d.deact = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (warm_rst_req && card_present) begin
                        r_d.state = ST_RST_LOW;
                        r_d.cnt   = '0;
                        r_d.vcc   = 1'b1;
                        r_d.rst_n = 1'b0;
                        r_d.rx    = 1'b1;
                    end
                end
                ST_RST_LOW: begin
                    if (warm_rst_req) begin
                        r_d.cnt = '0;
                    end else if (rst_hit) begin
                        r_d.state = ST_ATR_WATCH;
                        r_d.cnt   = '0;
                        r_d.rst_n = 1'b1;
                    end else if (card_clk_tick) begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                ST_ATR_WATCH: begin
                    if (rx_start_bit) begin
                        r_d.state = ST_ACTIVE;
                        r_d.cnt   = '0;
                        r_d.rx    = 1'b0;
                    end else if (warm_rst_req) begin
                        r_d.state = ST_RST_LOW;
                        r_d.cnt   = '0;
                        r_d.rst_n = 1'b0;
                    end else if (atr_hit) begin
                        r_d.state = ST_DEACT;
                        r_d.cnt   = '0;
                        r_d.rst_n = 1'b0;
                        r_d.rx    = 1'b0;
                        r_d.deact = 1'b1;
                        r_d.tout  = 1'b1;
                    end else if (card_clk_tick) begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                ST_ACTIVE: begin
                    if (warm_rst_req) begin
                        r_d.state = ST_RST_LOW;
                        r_d.cnt   = '0;
                        r_d.rst_n = 1'b0;
                        r_d.rx    = 1'b1;
                    end
                end
                ST_DEACT: begin
                    if (vcc_hit) r_d.vcc = 1'b0;
                    if (done_hit) begin
                        r_d.state = ST_IDLE;
                        r_d.cnt   = '0;
                        r_d.vcc   = 1'b0;
                    end else if (card_clk_tick) begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    r_d.state = ST_DEACT;
                    r_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.vcc   <= 1'b0;
            r_q.rst_n <= 1'b0;
            r_q.rx    <= 1'b0;
            r_q.deact <= 1'b0;
            r_q.cout  <= 1'b0;
            r_q.tout  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign card_rst_n     = r_q.rst_n;
    assign vcc_en         = r_q.vcc;
    assign rx_mode        = r_q.rx;
    assign deact_pulse    = r_q.deact;
    assign card_out_pulse = r_q.cout;
    assign atr_tout_pulse = r_q.tout;

    // R6: removal outside power-down lands in power-down with reset low
    a_r6_removal_deact: assert property (@(posedge clk) disable iff (!rst_n)
        (card_fall && r_q.state != ST_DEACT) |=> (r_q.state == ST_DEACT && !card_rst_n && deact_pulse));

    // R2: warm reset from active keeps the supply and drops reset
    a_r2_warm_keeps_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACTIVE && warm_rst_req && !card_fall && !sw_deact_req)
        |=> (vcc_en && !card_rst_n && rx_mode));

    // R5: a timeout pulse always comes with power-down and reset low
    a_r5_tout_deact: assert property (@(posedge clk) disable iff (!rst_n)
        atr_tout_pulse |-> (deact_pulse && !card_rst_n && r_q.state == ST_DEACT));

    // R9: power-down only leaves toward idle
    a_r9_deact_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DEACT) |=> (r_q.state == ST_DEACT || r_q.state == ST_IDLE));

    // R8: idle never has the supply on
    a_r8_idle_no_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !vcc_en);

    // R3: reset is released only while the supply is on
    a_r3_release_with_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> vcc_en);
endmodule

// File: tb/sim_card_rst_seq.sv
module sim_card_rst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm = 1'b0, swd = 1'b0, pres = 1'b1, tick = 1'b0, start = 1'b0;
    logic [15:0] rst_low = 16'd3;
    logic [15:0] atr_lim = 16'd5;
    logic        o_rstn, o_vcc, o_rx, o_deact, o_cout, o_tout;
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    card_rst_seq u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst_req(warm), .sw_deact_req(swd),
        .card_present(pres), .card_clk_tick(tick), .rx_start_bit(start),
        .rst_low_cycles(rst_low), .atr_limit(atr_lim),
        .card_rst_n(o_rstn), .vcc_en(o_vcc), .rx_mode(o_rx),
        .deact_pulse(o_deact), .card_out_pulse(o_cout), .atr_tout_pulse(o_tout)
    );

    // {req, warm pres tick start swd, rstn vcc rx deact cout tout}
    localparam int NVEC = 57;
    localparam logic [14:0] VEC [NVEC] = '{
        {4'd1, 5'b01000, 6'b000000},  // R1 idle after reset
        {4'd2, 5'b11000, 6'b011000},  // R2 warm from idle
        {4'd3, 5'b01100, 6'b011000},
        {4'd3, 5'b01100, 6'b011000},
        {4'd3, 5'b01000, 6'b011000},  // R3 no tick, no count
        {4'd3, 5'b01100, 6'b111000},  // R3 release on 3rd tick
        {4'd4, 5'b01100, 6'b111000},
        {4'd4, 5'b01010, 6'b110000},  // R4 early start bit
        {4'd2, 5'b11000, 6'b011000},  // R2 warm from active
        {4'd3, 5'b01100, 6'b011000},
        {4'd3, 5'b01100, 6'b011000},
        {4'd3, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b010101},  // R5 window expires
        {4'd9, 5'b11100, 6'b010000},  // R9 warm ignored in power-down
        {4'd8, 5'b01100, 6'b000000},  // R8 supply off on 2nd tick
        {4'd8, 5'b01100, 6'b000000},
        {4'd9, 5'b11100, 6'b000000},  // R9 back to idle, warm ignored
        {4'd2, 5'b11000, 6'b011000},
        {4'd3, 5'b01100, 6'b011000},
        {4'd3, 5'b01100, 6'b011000},
        {4'd3, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b111000},
        {4'd5, 5'b01100, 6'b111000},
        {4'd5, 5'b01110, 6'b110000},  // R5 start bit on expiring tick wins
        {4'd6, 5'b10010, 6'b010110},  // R6 removal beats start and warm
        {4'd8, 5'b00000, 6'b010000},
        {4'd8, 5'b00100, 6'b010000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd10, 5'b10000, 6'b000000}, // R10 warm without card
        {4'd10, 5'b01000, 6'b000000},
        {4'd2, 5'b11000, 6'b011000},
        {4'd6, 5'b00100, 6'b010110},  // R6 removal during reset low
        {4'd8, 5'b00100, 6'b010000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b01100, 6'b000000},
        {4'd7, 5'b01001, 6'b000100},  // R7 software power-down
        {4'd6, 5'b00000, 6'b000010},  // R6 removal inside power-down
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd6, 5'b01000, 6'b000000},
        {4'd6, 5'b00000, 6'b000110},  // R6 removal before activation
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd8, 5'b00100, 6'b000000},
        {4'd1, 5'b01000, 6'b000000}
    };

    function automatic logic [5:0] outs();
        return {o_rstn, o_vcc, o_rx, o_deact, o_cout, o_tout};
    endfunction

    task automatic check(input int req, input int idx, input logic [5:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_bad++;
            $display("FAIL R%0d step %0d: got %b expected %b", req, idx, outs(), exp);
        end
    endtask

    task automatic apply(input logic [14:0] v, input int idx);
        {warm, pres, tick, start, swd} = v[10:6];
        @(posedge clk);
        #1;
        check(int'(v[14:11]), idx, v[5:0]);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_bad++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, -1, 6'b000000);           // R1 outputs held during reset
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) apply(VEC[i], i);
        // R3 corner: zero hold length acts as one tick
        rst_low = 16'd0;
        apply({4'd2, 5'b11000, 6'b011000}, 100);
        apply({4'd3, 5'b01100, 6'b111000}, 101);
        // R7 software power-down from the watch state
        apply({4'd7, 5'b01001, 6'b010100}, 102);
        apply({4'd8, 5'b01100, 6'b010000}, 103);
        apply({4'd8, 5'b01100, 6'b000000}, 104);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule